// File: doc/BRIEF.md
# Execute-Stage Integer Arithmetic and Address Unit

This unit sits in the execute stage of a 32-bit load/store integer pipeline. In the same cycle it produces the arithmetic or logical result of a register operation and the effective address of a memory access. Its inputs are two register operands, a three-bit operation code, a sign-extended 16-bit displacement and an access-size code. The unit holds no state. The pipeline register that follows it captures every output.

The signed add and subtract operations raise an overflow trap. The unsigned add and subtract never do. When a memory access is requested, the unit forms the address from the first operand and the displacement, then checks that address against the natural alignment of the access size. Either trap drops the write-enable in the same cycle, so the faulting result never reaches the register file.

Top module: `alu_exec_unit`

## Requirements
- R1: Operation codes are ADD=3'b000, ADDU=3'b001, SUB=3'b010, SUBU=3'b011, AND=3'b100, OR=3'b101, SLT=3'b110, SLTU=3'b111. ADD and ADDU return `op_a + op_b` modulo 2^32.
- R2: SUB and SUBU return `op_a - op_b` modulo 2^32.
- R3: ADD raises `ovf_trap` exactly when both operands have the same sign bit and the sum's sign bit differs from it. ADDU never raises `ovf_trap`.
- R4: SUB raises `ovf_trap` exactly when the operand sign bits differ and the difference's sign bit differs from that of `op_a`. SUBU never raises `ovf_trap`.
- R5: AND and OR return the bitwise AND and the bitwise OR of the two operands.
- R6: SLT returns 1 when `op_a` is less than `op_b` as two's-complement numbers, and 0 otherwise, including when the operands are equal.
- R7: SLTU returns 1 when `op_a` is less than `op_b` as unsigned numbers, and 0 otherwise.
- R8: `eff_addr` always equals `op_a` plus `offset` sign-extended to 32 bits, modulo 2^32.
- R9: Access sizes are byte=2'b00, half=2'b01, word=2'b10 and 2'b11, where 2'b11 is checked as a word. With `mem_req` high, `misalign_trap` is raised when the address bit 0 is set for a half access, or when either of address bits 1:0 is set for a word access. A byte access never traps. With `mem_req` low, `misalign_trap` stays low.
- R10: `wr_en` is high when `in_valid` is high and neither trap is raised. Otherwise it is low.
- R11: While `in_valid` is low, `ovf_trap`, `misalign_trap` and `wr_en` are all low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | An operation is present this cycle |
| op_sel | input | 3 | Operation code (R1) |
| op_a | input | 32 | First operand; base register for addresses |
| op_b | input | 32 | Second operand |
| offset | input | 16 | Signed displacement for the address |
| mem_req | input | 1 | The operation is a load or a store; enables the alignment check |
| mem_size | input | 2 | Access size code (R9) |
| result | output | 32 | Arithmetic, logical or compare result |
| ovf_trap | output | 1 | Signed overflow exception |
| eff_addr | output | 32 | Effective memory address |
| misalign_trap | output | 1 | Misaligned access exception |
| wr_en | output | 1 | Writeback of `result` is allowed |

## Verification
The embedded checks assume that every input is at a defined 0 or 1 whenever they are evaluated. They also assume that a trap is meaningful only while `in_valid` is high. The stimulus satisfies this by driving all inputs to known values from time zero, and by changing them only at the falling clock edge. Each scenario applies inputs that exercise one behaviour in isolation: sign-boundary operands for the overflow rules, equal and sign-crossing pairs for the compares, and addresses that wrap around or have each low bit set for the address path. Some scenarios deliberately pair a request with in_valid low, to confirm that such a request stays silent.

// File: rtl/alu_exec_pkg.sv
// Shared encodings for the execute-stage arithmetic and address unit.
// Assumes: the op code and size code widths are fixed by the decode stage.
package alu_exec_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_ADDU = 3'b001,
        OP_SUB  = 3'b010,
        OP_SUBU = 3'b011,
        OP_AND  = 3'b100,
        OP_OR   = 3'b101,
        OP_SLT  = 3'b110,
        OP_SLTU = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WRSV = 2'b11
    } mem_size_e;
endpackage

// File: rtl/alu_addsub.sv
// Shared adder for add and subtract, with two's-complement overflow detection.
// Does: a + b, or a - b formed as a + ~b + 1. Overflow is reported only when
// chk_ovf is set. Assumes: the caller drives chk_ovf only for the signed ops.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_sub,
    input  logic         chk_ovf,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic         carry_out;

    // Invert the second operand and inject a carry to subtract.
    always_comb begin
        b_eff            = is_sub ? ~b : b;
        {carry_out, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
    end

    // Overflow: operands of the same sign produce a result of the other sign.
    always_comb begin
        ovf = chk_ovf && (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_logic_cmp.sv
// Bitwise AND/OR and the signed/unsigned set-less-than compares.
// Does: selects one of four functions using the two low op bits.
// Assumes: sel comes straight from op_sel[1:0].
module alu_logic_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] y
);
    logic lt_signed;
    logic lt_unsigned;

    // Form both orderings of the operands.
    always_comb begin
        lt_signed   = $signed(a) < $signed(b);
        lt_unsigned = a < b;
    end

    // Pick the requested function; the compares zero-extend a single bit.
    always_comb begin
        unique case (sel)
            2'b00:   y = a & b;
            2'b01:   y = a | b;
            2'b10:   y = {{(W-1){1'b0}}, lt_signed};
            default: y = {{(W-1){1'b0}}, lt_unsigned};
        endcase
    end

    // The compares must yield 0 or 1 only (R6, R7).
    always_comb begin
        if (sel[1]) begin
            p_cmp_bool_r6: assert (y[W-1:1] == '0)
                else $error("compare result wider than one bit");
        end
    end
endmodule

// File: rtl/alu_agu.sv
// Address generation and natural-alignment check for loads and stores.
// Does: base + sign-extended displacement, plus a misalignment flag for the
// access size. Assumes: chk is already qualified by the valid and request inputs.
module alu_agu
    import alu_exec_pkg::*;
#(
    parameter int W      = 32,
    parameter int OFFS_W = 16
) (
    input  logic [W-1:0]      base,
    input  logic [OFFS_W-1:0] offset,
    input  logic [1:0]        size,
    input  logic              chk,
    output logic [W-1:0]      addr,
    output logic              misalign
);
    localparam int EXT_W = W - OFFS_W;

    logic [W-1:0] offs_ext;

    // Sign-extend the displacement to the full width.
    generate
        if (EXT_W > 0) begin : g_ext
            assign offs_ext = {{EXT_W{offset[OFFS_W-1]}}, offset};
        end else begin : g_noext
            assign offs_ext = offset[W-1:0];
        end
    endgenerate

    // Form the effective address, wrapping modulo 2^W.
    always_comb begin
        addr = base + offs_ext;
    end

    // Test the low address bits against the access size.
    always_comb begin
        unique case (mem_size_e'(size))
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = chk && addr[0];
            default: misalign = chk && (addr[1:0] != 2'b00);
        endcase
    end

    // A byte access can never be misaligned (R9).
    always_comb begin
        if (size == SZ_BYTE) begin
            p_byte_never_traps_r9: assert (!misalign)
                else $error("byte access flagged misaligned");
        end
    end
endmodule

// File: rtl/alu_exec_unit.sv
// Execute-stage arithmetic and address unit (top).
// Does: result of the selected ALU op, a signed overflow trap, the effective
// address with an alignment trap, and a gated writeback enable.
// Assumes: purely combinational; the following pipeline register holds outputs.
module alu_exec_unit
    import alu_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFFS_W = 16
) (
    input  logic              in_valid,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [OFFS_W-1:0] offset,
    input  logic              mem_req,
    input  logic [1:0]        mem_size,
    output logic [DATA_W-1:0] result,
    output logic              ovf_trap,
    output logic [DATA_W-1:0] eff_addr,
    output logic              misalign_trap,
    output logic              wr_en
);
    logic              is_arith;
    logic              is_signed_arith;
    logic [DATA_W-1:0] arith_y;
    logic [DATA_W-1:0] logic_y;
    logic              arith_ovf;
    logic              agu_mis;

    // Decode the op class; only ADD and SUB (op bit 0 clear) check overflow.
    always_comb begin
        is_arith        = !op_sel[2];
        is_signed_arith = in_valid && is_arith && !op_sel[0];
    end

    alu_addsub #(.W(DATA_W)) u_addsub (
        .a       (op_a),
        .b       (op_b),
        .is_sub  (op_sel[1]),
        .chk_ovf (is_signed_arith),
        .sum     (arith_y),
        .ovf     (arith_ovf)
    );

    alu_logic_cmp #(.W(DATA_W)) u_logic (
        .a   (op_a),
        .b   (op_b),
        .sel (op_sel[1:0]),
        .y   (logic_y)
    );

    alu_agu #(.W(DATA_W), .OFFS_W(OFFS_W)) u_agu (
        .base     (op_a),
        .offset   (offset),
        .size     (mem_size),
        .chk      (in_valid && mem_req),
        .addr     (eff_addr),
        .misalign (agu_mis)
    );

    // Merge the datapaths and gate writeback on either exception.
    always_comb begin
        result        = is_arith ? arith_y : logic_y;
        ovf_trap      = arith_ovf;
        misalign_trap = agu_mis;
        wr_en         = in_valid && !arith_ovf && !agu_mis;
    end

    // Guards on the combined outputs.
    always_comb begin
        if (op_sel == OP_ADDU || op_sel == OP_SUBU) begin
            p_no_overflow_r3: assert (!ovf_trap)
                else $error("unsigned op raised overflow");
        end
        if (ovf_trap || misalign_trap) begin
            p_trap_blocks_write_r10: assert (!wr_en)
                else $error("write enabled during a trap");
        end
        if (!in_valid) begin
            p_idle_quiet_r11: assert (!ovf_trap && !misalign_trap && !wr_en)
                else $error("activity while not valid");
        end
        if (misalign_trap) begin
            p_mis_needs_req_r9: assert (mem_req)
                else $error("misalign without memory request");
        end
    end
endmodule

// File: tb/alu_exec_unit_tb.sv
module alu_exec_unit_tb;
    logic        clk = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = 3'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [15:0] offset = '0;
    logic        mem_req = 1'b0;
    logic [1:0]  mem_size = 2'b0;
    logic [31:0] result;
    logic        ovf_trap;
    logic [31:0] eff_addr;
    logic        misalign_trap;
    logic        wr_en;
    logic        rst_n = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alu_exec_unit u_dut (
        .in_valid(in_valid), .op_sel(op_sel), .op_a(op_a), .op_b(op_b),
        .offset(offset), .mem_req(mem_req), .mem_size(mem_size),
        .result(result), .ovf_trap(ovf_trap), .eff_addr(eff_addr),
        .misalign_trap(misalign_trap), .wr_en(wr_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, sample a quarter period later.
    task automatic apply(input logic v, input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [15:0] off,
                         input logic mr, input logic [1:0] sz);
        @(negedge clk);
        in_valid = v; op_sel = op; op_a = a; op_b = b;
        offset = off; mem_req = mr; mem_size = sz;
        #5;
    endtask

    // Register op: check result, overflow trap and writeback enable.
    task automatic t_reg(input string req, input logic [2:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] exp_y, input logic exp_ovf);
        apply(1'b1, op, a, b, 16'h0, 1'b0, 2'b10);
        chk(req, result, exp_y);
        chk(req, {31'b0, ovf_trap}, {31'b0, exp_ovf});
        chk("R10", {31'b0, wr_en}, {31'b0, !exp_ovf});
    endtask

    // Memory op: check the address and the misalignment trap.
    task automatic t_mem(input string req, input logic [31:0] base, input logic [15:0] off,
                         input logic mr, input logic [1:0] sz, input logic exp_mis);
        logic [31:0] exp_addr;
        exp_addr = base + {{16{off[15]}}, off};
        apply(1'b1, 3'b001, base, 32'h0, off, mr, sz);
        chk("R8", eff_addr, exp_addr);
        chk(req, {31'b0, misalign_trap}, {31'b0, exp_mis});
        chk("R10", {31'b0, wr_en}, {31'b0, !exp_mis});
    endtask

    task automatic t_idle();
        apply(1'b0, 3'b000, 32'h7fffffff, 32'h1, 16'h0001, 1'b1, 2'b10);
        chk("R11", {29'b0, ovf_trap, misalign_trap, wr_en}, 32'h0);
    endtask

    task automatic t_add();
        t_reg("R1", 3'b000, 32'd5, 32'd7, 32'd12, 1'b0);
        t_reg("R3", 3'b000, 32'h7fffffff, 32'h1, 32'h80000000, 1'b1);
        t_reg("R3", 3'b001, 32'h7fffffff, 32'h1, 32'h80000000, 1'b0);
        t_reg("R3", 3'b000, 32'hffffffff, 32'hffffffff, 32'hfffffffe, 1'b0);
        t_reg("R3", 3'b000, 32'h80000000, 32'h80000000, 32'h0, 1'b1);
        t_reg("R1", 3'b001, 32'hffffffff, 32'h2, 32'h1, 1'b0);
    endtask

    task automatic t_sub();
        t_reg("R2", 3'b010, 32'd10, 32'd3, 32'd7, 1'b0);
        t_reg("R4", 3'b010, 32'h80000000, 32'h1, 32'h7fffffff, 1'b1);
        t_reg("R4", 3'b011, 32'h80000000, 32'h1, 32'h7fffffff, 1'b0);
        t_reg("R4", 3'b010, 32'h0, 32'h80000000, 32'h80000000, 1'b1);
        t_reg("R4", 3'b010, 32'h7fffffff, 32'hffffffff, 32'h80000000, 1'b1);
        t_reg("R4", 3'b010, 32'hffffffff, 32'h7fffffff, 32'h80000000, 1'b0);
        t_reg("R2", 3'b011, 32'h0, 32'h1, 32'hffffffff, 1'b0);
    endtask

    task automatic t_logic();
        t_reg("R5", 3'b100, 32'hf0f0_ff00, 32'h3c3c_0ff0, 32'h3030_0f00, 1'b0);
        t_reg("R5", 3'b101, 32'hf0f0_ff00, 32'h3c3c_0ff0, 32'hfcfc_fff0, 1'b0);
        t_reg("R5", 3'b100, 32'hffffffff, 32'h0, 32'h0, 1'b0);
    endtask

    task automatic t_cmp();
        t_reg("R6", 3'b110, 32'hffffffff, 32'h1, 32'h1, 1'b0);
        t_reg("R6", 3'b110, 32'h1, 32'hffffffff, 32'h0, 1'b0);
        t_reg("R6", 3'b110, 32'h1234, 32'h1234, 32'h0, 1'b0);
        t_reg("R6", 3'b110, 32'h80000000, 32'h7fffffff, 32'h1, 1'b0);
        t_reg("R7", 3'b111, 32'hffffffff, 32'h1, 32'h0, 1'b0);
        t_reg("R7", 3'b111, 32'h1, 32'hffffffff, 32'h1, 1'b0);
        t_reg("R7", 3'b111, 32'h55, 32'h55, 32'h0, 1'b0);
    endtask

    task automatic t_addr();
        t_mem("R9", 32'h0000_1000, 16'hfffc, 1'b1, 2'b10, 1'b0);
        t_mem("R9", 32'h0000_1000, 16'h7fff, 1'b1, 2'b00, 1'b0);
        t_mem("R9", 32'h0000_1000, 16'h8000, 1'b1, 2'b00, 1'b0);
        t_mem("R9", 32'hffffffff, 16'h0001, 1'b1, 2'b10, 1'b0);
        t_mem("R9", 32'h0000_1000, 16'h0002, 1'b1, 2'b10, 1'b1);
        t_mem("R9", 32'h0000_1000, 16'h0002, 1'b1, 2'b11, 1'b1);
        t_mem("R9", 32'h0000_1000, 16'h0002, 1'b1, 2'b01, 1'b0);
        t_mem("R9", 32'h0000_1000, 16'h0001, 1'b1, 2'b01, 1'b1);
        t_mem("R9", 32'h0000_1003, 16'h0000, 1'b1, 2'b00, 1'b0);
        t_mem("R9", 32'h0000_1001, 16'h0000, 1'b0, 2'b10, 1'b0);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        #5;
        chk("R11", {29'b0, ovf_trap, misalign_trap, wr_en}, 32'h0);
        t_idle();
        t_add();
        t_sub();
        t_logic();
        t_cmp();
        t_addr();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule